// File: doc/BRIEF.md
# Bus Cycle Breakpoint Comparator

This block sits beside a processor bus in a debug subsystem and decides, once per bus cycle, whether that cycle is a breakpoint hit. Two small registers qualify the cycle: a compare register gives the wanted direction (read or write) and class (instruction fetch or data access), and a mask register marks either attribute as don't care. An address match arrives from an address comparator outside this block. The qualified result is registered and reported as a one-clock pulse.

The mode input picks how the break pin behaves. In single breakpoint mode the block drives the break pin. In multiple breakpoint mode the pin is an input from other breakpoint units, and it is ANDed into the internal match. In program break mode the two control registers are bypassed, and the hit depends only on the strobe and the address match. The bidirectional pin is split into an output, an output enable and an input, so that the pad can sit at chip level.

Top module: `bkpt_cycle_unit`

## Requirements
- R1: After a synchronous active-low reset, both control registers read 0x0000, and `brk_out` and `hit_int` are 0.
- R2: A write with `reg_sel`=0 updates the compare register. Bit 1 is the direction and bit 0 is the class. Bits REG_W-1..2 always read 0, and writes to them are ignored.
- R3: A write with `reg_sel`=1 updates the mask register, which has the same bit positions. Bits REG_W-1..2 read 0, and writes to them are ignored.
- R4: When mask bit 1 is 0, a cycle qualifies only if `bus_read` equals compare bit 1 (1 = read cycle, 0 = write cycle).
- R5: When mask bit 0 is 0, a cycle qualifies only if `bus_fetch` equals compare bit 0 (1 = instruction fetch, 0 = data cycle).
- R6: A mask bit of 1 makes the matching compare bit don't care.
- R7: In single mode (`mode`=0), `brk_oe` is 1. `brk_out` and `hit_int` are 1 in the clock after an edge where `bus_strobe`, `addr_hit` and the control match are all 1.
- R8: In multiple mode (`mode`=1), `brk_oe` and `brk_out` are 0. `hit_int` is 1 in the clock after an edge where `bus_strobe`, `addr_hit`, the control match and `brk_in` are all 1.
- R9: In program break mode (`mode`=2, and also 3), the registers have no effect. `hit_int` follows `bus_strobe` AND `addr_hit` one clock later. `brk_oe` and `brk_out` are 0.
- R10: With `bus_strobe` at 0 on an edge, neither `hit_int` nor `brk_out` is asserted in the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 0 single, 1 multiple, 2/3 program break |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 compare register, 1 mask register (write and read) |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data of the selected register |
| bus_strobe | input | 1 | Bus cycle valid this clock |
| bus_read | input | 1 | 1 read cycle, 0 write cycle |
| bus_fetch | input | 1 | 1 instruction fetch, 0 data cycle |
| addr_hit | input | 1 | Address match from the external comparator |
| brk_in | input | 1 | Break pin input value |
| brk_out | output | 1 | Break pin output value |
| brk_oe | output | 1 | Break pin output enable |
| hit_int | output | 1 | Registered internal match pulse |

## Verification
The bench builds the block with its default REG_W of 16. At this width the fourteen reserved positions above the two control bits are all present, so writes of all ones and random words show that only bits 1 and 0 are stored. All four mode codes are driven at random, including the spare code 3, so every mask and compare combination meets every pin direction.

// File: rtl/bkpt_pkg.sv
// Package: shared mode encoding and attribute bit positions for the
// breakpoint comparator. Assumes the two control registers share one layout.
package bkpt_pkg;
    typedef enum logic [1:0] {
        BK_SINGLE   = 2'd0,
        BK_MULTI    = 2'd1,
        BK_PROG     = 2'd2,
        BK_PROG_ALT = 2'd3
    } bk_mode_e;

    // Number of bus cycle attributes that are compared
    localparam int ATTR_N     = 2;
    // Attribute bit positions inside the compare and mask registers
    localparam int ATTR_DIR   = 1;
    localparam int ATTR_CLASS = 0;
endpackage

// File: rtl/bkpt_regs.sv
// Module: control compare and mask register pair.
// Only the low ATTR_N bits are stored. Reserved bits read as zero and
// ignore writes. Assumes reg_sel is stable during the clock of a write.
module bkpt_regs
    import bkpt_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic [ATTR_N-1:0] cmp_bits,
    output logic [ATTR_N-1:0] msk_bits
);
    localparam int RSV_W = REG_W - ATTR_N;

    logic [ATTR_N-1:0] cmp_q;
    logic [ATTR_N-1:0] msk_q;

    // Store the writable bits of the selected register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            msk_q <= '0;
        end else if (wr_en) begin
            if (sel) msk_q <= wdata[ATTR_N-1:0];
            else     cmp_q <= wdata[ATTR_N-1:0];
        end
    end

    // Zero-extend the selected register for reads
    always_comb begin
        rdata = {{RSV_W{1'b0}}, (sel ? msk_q : cmp_q)};
    end

    assign cmp_bits = cmp_q;
    assign msk_bits = msk_q;
endmodule

// File: rtl/bkpt_attr_cmp.sv
// Module: masked comparison of bus cycle attributes.
// Each attribute passes if it is masked or equal to its compare bit.
// Purely combinational. Assumes attributes are valid while the strobe is high.
module bkpt_attr_cmp
    import bkpt_pkg::*;
(
    input  logic [ATTR_N-1:0] cmp_bits,
    input  logic [ATTR_N-1:0] msk_bits,
    input  logic [ATTR_N-1:0] attr,
    output logic              ctrl_ok
);
    logic [ATTR_N-1:0] bit_ok;

    for (genvar i = 0; i < ATTR_N; i++) begin : g_bit
        // Per-attribute pass: masked, or equal to the compare bit
        always_comb begin
            bit_ok[i] = msk_bits[i] | ~(attr[i] ^ cmp_bits[i]);
        end
    end

    // All attributes must pass
    always_comb begin
        ctrl_ok = &bit_ok;
    end
endmodule

// File: rtl/bkpt_match.sv
// Module: mode-dependent match qualification and break pin control.
// Registers a one-clock hit per qualifying strobe. Codes 2 and 3 both select
// program break. The output enable follows the mode combinationally.
module bkpt_match
    import bkpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       strobe,
    input  logic       addr_hit,
    input  logic       ctrl_ok,
    input  logic       brk_in,
    output logic       brk_out,
    output logic       brk_oe,
    output logic       hit_int
);
    bk_mode_e mode_e;
    logic     qual;
    logic     drive_pin;
    logic     brk_q;
    logic     hit_q;

    assign mode_e = bk_mode_e'(mode);

    // Qualify the current cycle according to the mode
    always_comb begin
        unique case (mode_e)
            BK_SINGLE: qual = strobe & addr_hit & ctrl_ok;
            BK_MULTI:  qual = strobe & addr_hit & ctrl_ok & brk_in;
            default:   qual = strobe & addr_hit;
        endcase
        drive_pin = (mode_e == BK_SINGLE);
    end

    // Register the hit and the driven pin value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
            brk_q <= 1'b0;
        end else begin
            hit_q <= qual;
            brk_q <= qual & drive_pin;
        end
    end

    assign brk_out = brk_q;
    assign brk_oe  = drive_pin;
    assign hit_int = hit_q;
endmodule

// File: rtl/bkpt_cycle_unit.sv
// Module: top of the bus cycle breakpoint comparator.
// Joins the register pair, the attribute comparator and the mode logic.
// Assumes addr_hit comes from an external address comparator in the same clock.
module bkpt_cycle_unit
    import bkpt_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             bus_strobe,
    input  logic             bus_read,
    input  logic             bus_fetch,
    input  logic             addr_hit,
    input  logic             brk_in,
    output logic             brk_out,
    output logic             brk_oe,
    output logic             hit_int
);
    logic [ATTR_N-1:0] cmp_bits;
    logic [ATTR_N-1:0] msk_bits;
    logic [ATTR_N-1:0] attr;
    logic              ctrl_ok;

    // Pack the bus attributes into register bit order
    always_comb begin
        attr             = '0;
        attr[ATTR_DIR]   = bus_read;
        attr[ATTR_CLASS] = bus_fetch;
    end

    bkpt_regs #(.REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .cmp_bits (cmp_bits),
        .msk_bits (msk_bits)
    );

    bkpt_attr_cmp u_cmp (
        .cmp_bits (cmp_bits),
        .msk_bits (msk_bits),
        .attr     (attr),
        .ctrl_ok  (ctrl_ok)
    );

    bkpt_match u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .strobe   (bus_strobe),
        .addr_hit (addr_hit),
        .ctrl_ok  (ctrl_ok),
        .brk_in   (brk_in),
        .brk_out  (brk_out),
        .brk_oe   (brk_oe),
        .hit_int  (hit_int)
    );
endmodule

// File: rtl/bkpt_cycle_chk.sv
// Module: assertion checker bound to bkpt_cycle_unit.
// Observes the top-level ports only.
module bkpt_cycle_chk #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [REG_W-1:0] reg_rdata,
    input logic             bus_strobe,
    input logic             addr_hit,
    input logic             brk_in,
    input logic             brk_out,
    input logic             hit_int
);
    // R2/R3: reserved bits never read back as ones
    a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[REG_W-1:2] == '0);

    // R10: no strobe means no hit in the next clock
    a_r10_no_strobe_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> (!hit_int && !brk_out));

    // R7: no address match means the pin is not driven high
    a_r7_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_hit |=> !brk_out);

    // R8: a low break input blocks the internal match in multiple mode
    a_r8_pin_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && !brk_in) |=> !hit_int);

    // R9: program break hits on strobe and address alone
    a_r9_prog_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && bus_strobe && addr_hit) |=> (hit_int && !brk_out));

    // R7: the pin is only pulsed after a single-mode edge
    a_r7_out_single_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'd0) |=> !brk_out);
endmodule

bind bkpt_cycle_unit bkpt_cycle_chk #(.REG_W(REG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .reg_rdata  (reg_rdata),
    .bus_strobe (bus_strobe),
    .addr_hit   (addr_hit),
    .brk_in     (brk_in),
    .brk_out    (brk_out),
    .hit_int    (hit_int)
);

// File: tb/sim_bkpt_cycle_unit.sv
// Bench: directed corner cases and seeded random cycles against a reference model.
module sim_bkpt_cycle_unit;
    localparam int REG_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       mode = 2'd0;
    logic             reg_wr = 1'b0;
    logic             reg_sel = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             bus_strobe = 1'b0;
    logic             bus_read = 1'b0;
    logic             bus_fetch = 1'b0;
    logic             addr_hit = 1'b0;
    logic             brk_in = 1'b0;
    logic             brk_out;
    logic             brk_oe;
    logic             hit_int;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference state
    logic [1:0] m_cmp = 2'b00;
    logic [1:0] m_msk = 2'b00;
    logic       e_hit = 1'b0;
    logic       e_brk = 1'b0;
    string      e_tag = "R1";

    always #5 clk = ~clk;

    bkpt_cycle_unit #(.REG_W(REG_W)) u0 (.*);

    function automatic logic f_ctrl(logic [1:0] c, logic [1:0] k, logic rd, logic fe);
        logic ok_d = k[1] || (rd == c[1]);
        logic ok_c = k[0] || (fe == c[0]);
        return ok_d && ok_c;
    endfunction

    function automatic logic f_hit(logic [1:0] md, logic [1:0] c, logic [1:0] k,
                                   logic st, logic rd, logic fe, logic ah, logic bi);
        if (!st || !ah) return 1'b0;
        if (md == 2'd0) return f_ctrl(c, k, rd, fe);
        if (md == 2'd1) return f_ctrl(c, k, rd, fe) && bi;
        return 1'b1;
    endfunction

    task automatic chk(string tag, logic [REG_W-1:0] act, logic [REG_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Check the previous cycle's outcome, then drive one new cycle
    task automatic step(string tag, logic [1:0] md, logic wr, logic sel,
                        logic [REG_W-1:0] wd, logic st, logic rd, logic fe,
                        logic ah, logic bi);
        @(negedge clk);
        chk(e_tag, {15'd0, hit_int}, {15'd0, e_hit});
        chk(e_tag, {15'd0, brk_out}, {15'd0, e_brk});
        chk((reg_sel ? "R3" : "R2"), reg_rdata, {14'd0, (reg_sel ? m_msk : m_cmp)});
        chk((mode == 2'd0) ? "R7" : ((mode == 2'd1) ? "R8" : "R9"),
            {15'd0, brk_oe}, {15'd0, (mode == 2'd0)});
        mode = md; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
        bus_strobe = st; bus_read = rd; bus_fetch = fe; addr_hit = ah; brk_in = bi;
        e_hit = f_hit(md, m_cmp, m_msk, st, rd, fe, ah, bi);
        e_brk = e_hit && (md == 2'd0);
        e_tag = tag;
        if (wr) begin
            if (sel) m_msk = wd[1:0];
            else     m_cmp = wd[1:0];
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        chk("R1", reg_rdata, '0);
        chk("R1", {15'd0, hit_int}, '0);
        chk("R1", {15'd0, brk_out}, '0);
        reg_sel = 1'b1;
        #1 chk("R1", reg_rdata, '0);
        reg_sel = 1'b0;

        // R2/R3: all-ones writes keep only bits 1..0
        step("R2", 2'd0, 1'b1, 1'b0, 16'hFFFF, 0, 0, 0, 0, 0);
        step("R3", 2'd0, 1'b1, 1'b1, 16'hFFFC, 0, 0, 0, 0, 0);
        step("R3", 2'd0, 1'b0, 1'b1, 16'h0000, 0, 0, 0, 0, 0);
        // R4/R5: compare = read fetch, mask clear
        step("R4", 2'd0, 1'b0, 1'b0, 16'h0, 1, 1, 1, 1, 0);
        step("R4", 2'd0, 1'b0, 1'b0, 16'h0, 1, 0, 1, 1, 0);
        step("R5", 2'd0, 1'b0, 1'b0, 16'h0, 1, 1, 0, 1, 0);
        // R6: mask direction, then class
        step("R6", 2'd0, 1'b1, 1'b1, 16'h0002, 0, 0, 0, 0, 0);
        step("R6", 2'd0, 1'b0, 1'b0, 16'h0, 1, 0, 1, 1, 0);
        step("R6", 2'd0, 1'b0, 1'b0, 16'h0, 1, 0, 0, 1, 0);
        // R8: multiple mode gated by pin input
        step("R8", 2'd1, 1'b0, 1'b0, 16'h0, 1, 1, 1, 1, 0);
        step("R8", 2'd1, 1'b0, 1'b0, 16'h0, 1, 1, 1, 1, 1);
        // R9: program mode ignores registers
        step("R9", 2'd2, 1'b0, 1'b0, 16'h0, 1, 0, 0, 1, 0);
        step("R9", 2'd3, 1'b0, 1'b0, 16'h0, 1, 0, 0, 1, 0);
        // R10: no strobe
        step("R10", 2'd0, 1'b0, 1'b0, 16'h0, 0, 1, 1, 1, 1);
        step("R10", 2'd2, 1'b0, 1'b0, 16'h0, 0, 1, 1, 1, 1);

        void'($urandom(32'd2024));
        for (int i = 0; i < 3000; i++) begin
            logic [1:0] md = 2'($urandom_range(0, 3));
            logic       st = ($urandom_range(0, 3) != 0);
            string      tg;
            tg = (!st) ? "R10" : ((md == 2'd0) ? "R7" : ((md == 2'd1) ? "R8" : "R9"));
            step(tg, md, ($urandom_range(0, 7) == 0), 1'($urandom),
                 16'($urandom), st, 1'($urandom), 1'($urandom),
                 ($urandom_range(0, 3) != 0), 1'($urandom));
        end
        step("R10", 2'd0, 1'b0, 1'b0, 16'h0, 0, 0, 0, 0, 0);
        step("R10", 2'd0, 1'b0, 1'b0, 16'h0, 0, 0, 0, 0, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule